// File: doc/BRIEF.md
# ATA Device-Side Reset Controller

This block lives inside one drive on a shared two-drive ATA/ATAPI cable. It watches host writes to the Device Control register and to the Command register and decides which kind of reset the drive must run: a hardware reset from the RESET- pin, a software reset from the SRST bit, or a device reset. A device reset comes either from the drive's own per-drive reset bit in Device Control or from the device-reset command code. Only the device with the matching strap obeys its per-drive bit, so the host can reset one drive without selecting it and without disturbing the other drive.

Once a reset is chosen, the block emits a one-cycle start pulse for that reset class and holds BSY for a fixed number of clocks. When the sequence completes it emits a one-cycle done pulse tagged with the class. For hardware and software resets it also emits a PDIAG toggle request. The classes have a fixed priority: hardware over software over device. A higher class restarts the sequence, and a lower class is not accepted while any sequence runs. The block also produces the INTRQ drive enable from the stored nIEN bit and the device-select state. Media and firmware re-initialisation and the bus drivers are outside this block.

Top module: `ata_rst_ctl`

## Requirements
- R1: While RESET- is low, bsy=1, start_hard=1, start_soft=0, start_dev=0, done_vld=0 and the stored control bits are cleared. After release, bsy stays 1 for BUSY_CYC clocks, then done_vld pulses with done_cls=3 and pdiag_tgl=1.
- R2: Device Control writes are accepted whatever dev_sel is. Field positions are: bit 5 reset for device 1, bit 4 reset for device 0, bit 2 SRST, bit 1 nIEN. Bits 7, 6, 3 and 0 are ignored.
- R3: With dev_strap=0 only bit 4 can start a device reset, and with dev_strap=1 only bit 5 can. The partner's bit has no effect, including when dev_sel selects the partner.
- R4: A reset bit triggers only on a 0-to-1 change against the value stored by the previous Device Control write. Writing 1 again does not retrigger, and writing 0 re-arms the bit.
- R5: A 0-to-1 change of SRST starts a software reset. Any write with SRST=1 ignores both per-drive reset bits.
- R6: A Command register write of 8'h08 starts a device reset only when dev_sel equals dev_strap and sleeping=0. Any other code, the unselected drive, or sleeping=1 gives no reset.
- R7: Device Control triggers (SRST and the per-drive bit) are honoured while sleeping=1.
- R8: The start pulse for an accepted trigger appears in the cycle after the write edge, with bsy=1. bsy stays 1 for BUSY_CYC cycles. done_vld then pulses for one cycle with bsy=0 and done_cls set to 1 (device), 2 (software) or 3 (hardware).
- R9: pdiag_tgl pulses together with done_vld for software and hardware resets, and never for a device reset.
- R10: A software reset triggered during a device reset restarts the count as a software reset. The preempted device reset produces no done pulse.
- R11: While bsy=1, device-reset triggers from either source are ignored, and an SRST trigger during a hardware reset is ignored. The running sequence finishes on its original schedule.
- R12: Asserting RESET- during any sequence aborts it and restarts the hardware reset from the beginning.
- R13: intrq_oe=1 exactly when the stored nIEN is 0 and dev_sel equals dev_strap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pin_n | input | 1 | Bus RESET- pin, active low, asynchronous |
| dc_wr | input | 1 | Device Control write strobe |
| cmd_wr | input | 1 | Command register write strobe |
| wr_data | input | 8 | Data of the register write |
| dev_strap | input | 1 | Static drive number (0 or 1) |
| dev_sel | input | 1 | Current DEV select bit |
| sleeping | input | 1 | Drive is in sleep mode |
| bsy | output | 1 | BSY status during a reset sequence |
| start_hard | output | 1 | Hardware reset start indication |
| start_soft | output | 1 | Software reset start pulse |
| start_dev | output | 1 | Device reset start pulse |
| done_vld | output | 1 | One-cycle completion pulse |
| done_cls | output | 2 | Class that completed (1 dev, 2 soft, 3 hard) |
| pdiag_tgl | output | 1 | PDIAG toggle request |
| intrq_oe | output | 1 | INTRQ drive enable |

## Verification
Each start pulse and the rise of bsy are due one clock after the edge that samples the write. The bench drives on the falling edge and checks at the following falling edge. bsy is checked to stay high at each of the next BUSY_CYC-1 falling edges, and done_vld, done_cls and pdiag_tgl are checked exactly BUSY_CYC edges after the trigger edge. A preempting SRST restarts that count from its own write edge, and an ignored request leaves the original schedule in force. intrq_oe is combinational from stored nIEN, so it is checked in the cycle after the write.

// File: rtl/ata_rst_pkg.sv
package ata_rst_pkg;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_DEV  = 2'd1,
        CLS_SOFT = 2'd2,
        CLS_HARD = 2'd3
    } rst_cls_e;

    // Device Control field positions decoded by both drives
    localparam int DC_DEV0_BIT = 4;
    localparam int DC_DEV1_BIT = 5;
    localparam int DC_SRST_BIT = 2;
    localparam int DC_NIEN_BIT = 1;

    localparam logic [7:0] CMD_DEV_RESET = 8'h08;

    typedef struct packed {
        logic dev0_rst;
        logic dev1_rst;
        logic srst;
        logic nien;
    } dctl_t;

endpackage

// File: rtl/ata_dctl_dec.sv
module ata_dctl_dec
    import ata_rst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dc_wr,
    input  logic       cmd_wr,
    input  logic [7:0] wr_data,
    input  logic       dev_strap,
    input  logic       dev_sel,
    input  logic       sleeping,
    output logic       soft_trig,
    output logic       dev_trig,
    output logic       nien
);

    typedef struct packed {
        dctl_t ctl;
    } dec_state_t;

    dec_state_t st_q, st_d;
    dctl_t      wr_ctl;
    logic       own_new;
    logic       own_old;
    logic       dc_dev;
    logic       cmd_dev;

    always_comb begin
        wr_ctl.dev0_rst = wr_data[DC_DEV0_BIT];
        wr_ctl.dev1_rst = wr_data[DC_DEV1_BIT];
        wr_ctl.srst     = wr_data[DC_SRST_BIT];
        wr_ctl.nien     = wr_data[DC_NIEN_BIT];

        st_d = st_q;
        if (dc_wr) begin
            st_d.ctl = wr_ctl;
        end

        // each drive looks only at its own per-drive reset bit
        own_new = dev_strap ? wr_ctl.dev1_rst : wr_ctl.dev0_rst;
        own_old = dev_strap ? st_q.ctl.dev1_rst : st_q.ctl.dev0_rst;

        soft_trig = dc_wr && wr_ctl.srst && !st_q.ctl.srst;
        dc_dev    = dc_wr && !wr_ctl.srst && own_new && !own_old;
        cmd_dev   = cmd_wr && !dc_wr && !sleeping
                    && (dev_sel == dev_strap) && (wr_data == CMD_DEV_RESET);
        dev_trig  = dc_dev || cmd_dev;
        nien      = st_q.ctl.nien;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ata_rst_seq.sv
module ata_rst_seq
    import ata_rst_pkg::*;
#(
    parameter int BUSY_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_trig,
    input  logic       dev_trig,
    output logic       bsy,
    output logic       start_hard,
    output logic       start_soft,
    output logic       start_dev,
    output logic       done_vld,
    output logic [1:0] done_cls,
    output logic       pdiag_tgl
);

    localparam int CNT_W = (BUSY_CYC > 2) ? $clog2(BUSY_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BUSY_CYC - 1);

    typedef struct packed {
        logic             busy;
        rst_cls_e         cls;
        logic [CNT_W-1:0] cnt;
        logic             st_hard;
        logic             st_soft;
        logic             st_dev;
        logic             done;
        rst_cls_e         done_cls;
        logic             pdiag;
    } seq_state_t;

    seq_state_t q, d;
    logic       soft_ok;
    logic       dev_ok;

    always_comb begin
        d         = q;
        d.st_hard = 1'b0;
        d.st_soft = 1'b0;
        d.st_dev  = 1'b0;
        d.done    = 1'b0;
        d.pdiag   = 1'b0;

        if (q.busy) begin
            if (q.cnt == CNT_LAST) begin
                d.busy     = 1'b0;
                d.cnt      = '0;
                d.done     = 1'b1;
                d.done_cls = q.cls;
                d.pdiag    = (q.cls != CLS_DEV);
                d.cls      = CLS_NONE;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end

        // priority: hardware (async pin) > software > device
        soft_ok = soft_trig && (!q.busy || q.cls != CLS_HARD);
        dev_ok  = dev_trig && !soft_trig && !q.busy;

        if (soft_ok) begin
            d.busy    = 1'b1;
            d.cls     = CLS_SOFT;
            d.cnt     = '0;
            d.st_soft = 1'b1;
            d.done    = 1'b0;
            d.pdiag   = 1'b0;
        end else if (dev_ok) begin
            d.busy   = 1'b1;
            d.cls    = CLS_DEV;
            d.cnt    = '0;
            d.st_dev = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.busy     <= 1'b1;
            q.cls      <= CLS_HARD;
            q.st_hard  <= 1'b1;
            q.done_cls <= CLS_NONE;
        end else begin
            q <= d;
        end
    end

    assign bsy        = q.busy;
    assign start_hard = q.st_hard;
    assign start_soft = q.st_soft;
    assign start_dev  = q.st_dev;
    assign done_vld   = q.done;
    assign done_cls   = q.done ? q.done_cls : CLS_NONE;
    assign pdiag_tgl  = q.pdiag;

endmodule

// File: rtl/ata_irq_gate.sv
module ata_irq_gate (
    input  logic nien,
    input  logic dev_strap,
    input  logic dev_sel,
    output logic intrq_oe
);

    always_comb begin
        intrq_oe = !nien && (dev_sel == dev_strap);
    end

endmodule

// File: rtl/ata_rst_ctl.sv
module ata_rst_ctl #(
    parameter int BUSY_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_pin_n,
    input  logic       dc_wr,
    input  logic       cmd_wr,
    input  logic [7:0] wr_data,
    input  logic       dev_strap,
    input  logic       dev_sel,
    input  logic       sleeping,
    output logic       bsy,
    output logic       start_hard,
    output logic       start_soft,
    output logic       start_dev,
    output logic       done_vld,
    output logic [1:0] done_cls,
    output logic       pdiag_tgl,
    output logic       intrq_oe
);

    logic soft_trig;
    logic dev_trig;
    logic nien;

    ata_dctl_dec u_dec (
        .clk       (clk),
        .rst_n     (rst_pin_n),
        .dc_wr     (dc_wr),
        .cmd_wr    (cmd_wr),
        .wr_data   (wr_data),
        .dev_strap (dev_strap),
        .dev_sel   (dev_sel),
        .sleeping  (sleeping),
        .soft_trig (soft_trig),
        .dev_trig  (dev_trig),
        .nien      (nien)
    );

    ata_rst_seq #(
        .BUSY_CYC (BUSY_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_pin_n),
        .soft_trig  (soft_trig),
        .dev_trig   (dev_trig),
        .bsy        (bsy),
        .start_hard (start_hard),
        .start_soft (start_soft),
        .start_dev  (start_dev),
        .done_vld   (done_vld),
        .done_cls   (done_cls),
        .pdiag_tgl  (pdiag_tgl)
    );

    ata_irq_gate u_irq (
        .nien      (nien),
        .dev_strap (dev_strap),
        .dev_sel   (dev_sel),
        .intrq_oe  (intrq_oe)
    );

endmodule

// File: rtl/ata_rst_chk.sv
module ata_rst_chk
    import ata_rst_pkg::*;
(
    input logic       clk,
    input logic       rst_pin_n,
    input logic       dc_wr,
    input logic       cmd_wr,
    input logic       dev_strap,
    input logic       dev_sel,
    input logic       sleeping,
    input logic       bsy,
    input logic       start_hard,
    input logic       start_soft,
    input logic       start_dev,
    input logic       done_vld,
    input logic [1:0] done_cls,
    input logic       pdiag_tgl,
    input logic       intrq_oe
);

    // R8
    start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        $onehot0({start_hard, start_soft, start_dev}));

    // R8
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        done_vld |-> !bsy);

    // R8
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (start_soft || start_dev) |-> bsy);

    // R9
    pdiag_class_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        pdiag_tgl |-> (done_vld && done_cls != CLS_DEV));

    // R6
    sleep_cmd_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (cmd_wr && sleeping && !dc_wr) |=> !start_dev);

    // R11
    busy_no_dev_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        bsy |=> !start_dev);

    // R13
    irq_unsel_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (dev_sel != dev_strap) |-> !intrq_oe);

endmodule

bind ata_rst_ctl ata_rst_chk u_chk (
    .clk        (clk),
    .rst_pin_n  (rst_pin_n),
    .dc_wr      (dc_wr),
    .cmd_wr     (cmd_wr),
    .dev_strap  (dev_strap),
    .dev_sel    (dev_sel),
    .sleeping   (sleeping),
    .bsy        (bsy),
    .start_hard (start_hard),
    .start_soft (start_soft),
    .start_dev  (start_dev),
    .done_vld   (done_vld),
    .done_cls   (done_cls),
    .pdiag_tgl  (pdiag_tgl),
    .intrq_oe   (intrq_oe)
);

// File: tb/sim_ata_rst_ctl.sv
module sim_ata_rst_ctl;

    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_pin_n = 1'b0;
    logic       dc_wr = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       dev_strap = 1'b0;
    logic       dev_sel = 1'b0;
    logic       sleeping = 1'b0;
    logic       bsy, start_hard, start_soft, start_dev;
    logic       done_vld, pdiag_tgl, intrq_oe;
    logic [1:0] done_cls;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ata_rst_ctl #(.BUSY_CYC(N)) u0 (
        .clk(clk), .rst_pin_n(rst_pin_n), .dc_wr(dc_wr), .cmd_wr(cmd_wr),
        .wr_data(wr_data), .dev_strap(dev_strap), .dev_sel(dev_sel),
        .sleeping(sleeping), .bsy(bsy), .start_hard(start_hard),
        .start_soft(start_soft), .start_dev(start_dev), .done_vld(done_vld),
        .done_cls(done_cls), .pdiag_tgl(pdiag_tgl), .intrq_oe(intrq_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // nibble = {dev1 bit, dev0 bit, srst, nien} -> Device Control byte
    function automatic logic [7:0] mk(input logic [3:0] nib);
        return {2'b00, nib[3], nib[2], 1'b0, nib[1], nib[0], 1'b0};
    endfunction

    task automatic pulse_dc(input logic [7:0] d);
        dc_wr = 1'b1; wr_data = d;
        @(negedge clk);
        dc_wr = 1'b0; wr_data = '0;
    endtask

    task automatic pulse_cmd(input logic [7:0] d);
        cmd_wr = 1'b1; wr_data = d;
        @(negedge clk);
        cmd_wr = 1'b0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // called one half cycle after the trigger edge
    task automatic run_out(input int cls, input int pd, input string req);
        for (int i = 1; i < N; i++) begin
            @(negedge clk);
            chk({req, " bsy held"}, bsy, 1);
            chk({req, " no early done"}, done_vld, 0);
        end
        @(negedge clk);
        chk({req, " bsy clear"}, bsy, 0);
        chk({req, " done"}, done_vld, 1);
        chk({req, " done_cls"}, done_cls, cls);
        chk({req, " pdiag"}, pdiag_tgl, pd);
        @(negedge clk);
        chk({req, " done one cycle"}, done_vld, 0);
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_pin_n = 1'b0;
        dev_strap = strap;
        dev_sel = strap;
        @(negedge clk);
        chk("R1 bsy in reset", bsy, 1);
        chk("R1 start_hard in reset", start_hard, 1);
        chk("R1 no soft start", start_soft, 0);
        chk("R1 no dev start", start_dev, 0);
        chk("R1 no done", done_vld, 0);
        chk("R1 R13 nIEN cleared", intrq_oe, 1);
        rst_pin_n = 1'b1;
        run_out(3, 1, "R1 hard");
    endtask

    initial begin
        int own_p, own_n, e_soft, e_dev;
        for (int s = 0; s < 2; s++) begin
            do_reset(s[0]);
            for (int p = 0; p < 16; p++) begin
                for (int n = 0; n < 16; n++) begin
                    sleeping = p[3];
                    dev_sel = p[0] ^ n[2];
                    pulse_dc(8'h00);
                    idle(N + 2);
                    pulse_dc(mk(p[3:0]) | 8'hC9);
                    idle(N + 2);
                    own_p = s ? p[3] : p[2];
                    own_n = s ? n[3] : n[2];
                    e_soft = n[1] & ~p[1];
                    e_dev = ~n[1] & own_n & ~own_p;
                    pulse_dc(mk(n[3:0]));
                    // R2 R7: accepted regardless of dev_sel or sleeping
                    chk("R5 soft start", start_soft, e_soft);
                    chk("R3 R4 own bit dev start", start_dev, e_dev);
                    chk("R2 bsy", bsy, e_soft | e_dev);
                    chk("R13 intrq_oe", intrq_oe,
                        (!n[0] && (dev_sel == s[0])) ? 1 : 0);
                    idle(N + 2);
                end
            end
        end
        sleeping = 1'b0;

        // R11: software trigger during hardware reset ignored
        do_reset(1'b0);
        pulse_dc(8'h00);
        idle(N + 2);
        rst_pin_n = 1'b0;
        @(negedge clk);
        rst_pin_n = 1'b1;
        @(negedge clk);
        pulse_dc(8'h04);
        chk("R11 soft ignored in hard", start_soft, 0);
        chk("R11 bsy", bsy, 1);
        for (int k = 3; k < N; k++) begin
            @(negedge clk);
            chk("R11 bsy held", bsy, 1);
        end
        @(negedge clk);
        chk("R11 hard done", done_vld, 1);
        chk("R11 hard cls", done_cls, 3);
        idle(2);

        // R6: command path
        dev_sel = 1'b0;
        pulse_cmd(8'h08);
        chk("R6 cmd dev start", start_dev, 1);
        run_out(1, 0, "R6 R9 dev");
        dev_sel = 1'b1;
        pulse_cmd(8'h08);
        chk("R6 unselected ignored", start_dev, 0);
        chk("R6 unselected bsy", bsy, 0);
        dev_sel = 1'b0;
        sleeping = 1'b1;
        pulse_cmd(8'h08);
        chk("R6 sleeping ignored", start_dev, 0);
        chk("R6 sleeping bsy", bsy, 0);
        sleeping = 1'b0;
        pulse_cmd(8'h90);
        chk("R6 other code ignored", start_dev, 0);
        chk("R6 other code bsy", bsy, 0);

        // R7: Device Control triggers honoured while sleeping
        sleeping = 1'b1;
        pulse_dc(8'h00);
        idle(2);
        pulse_dc(8'h10);
        chk("R7 dev start asleep", start_dev, 1);
        run_out(1, 0, "R7 R9 dev");
        pulse_dc(8'h00);
        idle(2);
        pulse_dc(8'h04);
        chk("R7 soft start asleep", start_soft, 1);
        run_out(2, 1, "R7 R9 soft");
        sleeping = 1'b0;

        // R10: software preempts device reset
        pulse_dc(8'h00);
        idle(N + 2);
        pulse_dc(8'h10);
        chk("R10 dev start", start_dev, 1);
        idle(3);
        pulse_dc(8'h14);
        chk("R10 soft preempt", start_soft, 1);
        run_out(2, 1, "R10 soft");

        // R11: device requests during software reset ignored
        pulse_dc(8'h00);
        idle(N + 2);
        pulse_dc(8'h04);
        chk("R11 soft start", start_soft, 1);
        idle(2);
        pulse_dc(8'h10);
        chk("R11 dc dev ignored", start_dev, 0);
        chk("R11 bsy dc", bsy, 1);
        dev_sel = 1'b0;
        pulse_cmd(8'h08);
        chk("R11 cmd dev ignored", start_dev, 0);
        for (int i = 5; i < N; i++) begin
            @(negedge clk);
            chk("R11 bsy orig", bsy, 1);
        end
        @(negedge clk);
        chk("R11 orig done", done_vld, 1);
        chk("R11 orig cls", done_cls, 2);
        idle(2);

        // R12: RESET- mid device reset restarts hardware reset
        pulse_dc(8'h00);
        idle(N + 2);
        pulse_dc(8'h10);
        chk("R12 dev start", start_dev, 1);
        idle(2);
        rst_pin_n = 1'b0;
        #1;
        chk("R12 bsy", bsy, 1);
        chk("R12 start_hard", start_hard, 1);
        chk("R12 dev start dropped", start_dev, 0);
        @(negedge clk);
        rst_pin_n = 1'b1;
        run_out(3, 1, "R12 hard");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R8 watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule